// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit turns the addressing information of one memory-operand instruction into the byte address the load/store path presents to memory. A 3-bit mode code selects how the address is formed from two register values (a base and an index) and a 16-bit field taken from the instruction word. The field is either a displacement or an absolute address. For the two self-adjusting pointer modes, the unit also returns the new pointer value together with a write enable, and the register file stores that value in the base register. The operand size (byte or word) sets how far the pointer moves.

The arithmetic is purely combinational. A parameter places an optional register stage on all three outputs, which then appear one clock after their inputs. All sums are taken modulo 2^ADDR_W and no carry or overflow is reported. The register file and the memory access itself sit outside the unit.

Top module: `eag_unit`

## Requirements
- R1: Mode code 0 (absolute) gives `ea_o` equal to the 16-bit field sign-extended to 32 bits.
- R2: Mode code 1 (register indirect) gives `ea_o` equal to `base_i`.
- R3: Mode code 2 (displaced) gives `ea_o` equal to `base_i` plus the sign-extended field.
- R4: Mode code 3 (base plus index) gives `ea_o` equal to `base_i` plus `index_i` plus the sign-extended field.
- R5: Mode code 4 (post-increment) gives `ea_o` equal to the unmodified `base_i`, `ptr_o` equal to `base_i` plus the step, and `ptr_we_o` equal to 1.
- R6: Mode code 5 (pre-decrement) gives `ea_o` and `ptr_o` both equal to `base_i` minus the step, and `ptr_we_o` equal to 1.
- R7: The step is 4 when `size_i` is 1 (word operand) and 1 when `size_i` is 0 (byte operand).
- R8: In modes 0 to 3, `ptr_we_o` is 0 and `ptr_o` equals `base_i`.
- R9: Every sum and difference wraps modulo 2^32 and no overflow is flagged. For example, post-increment of word 0xFFFFFFFE yields pointer 0x00000002.
- R10: Reserved mode codes 6 and 7 give `ea_o` equal to 0, `ptr_we_o` equal to 0 and `ptr_o` equal to `base_i`.
- R11: When REG_OUT is 1, the outputs reflect the inputs sampled at the previous rising clock edge, and all outputs are 0 while `rst_n` is low. When REG_OUT is 0, the outputs follow the inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register stage |
| rst_n | input | 1 | Active-low synchronous reset of the output register stage |
| mode_i | input | 3 | Addressing mode code (0 to 5 defined, 6 and 7 reserved) |
| size_i | input | 1 | Operand size: 0 for byte, 1 for word |
| base_i | input | 32 | Base or pointer register value |
| index_i | input | 32 | Index register value |
| field_i | input | 16 | Displacement or absolute field from the instruction |
| ea_o | output | 32 | Effective byte address |
| ptr_o | output | 32 | Updated pointer value |
| ptr_we_o | output | 1 | Pointer writeback enable |

## Verification
The hardest situations to reach are the ones where the address arithmetic crosses the top or bottom of the address space. In these cases the two self-adjusting modes must differ in whether the wrapped value or the original one becomes the address. The stimulus reaches them by placing the pointer one step from either end of the range and applying both operand sizes. It also drives base-plus-index with operands whose three-way sum carries out twice. A second instance built without the register stage is checked in the same cycle, so that the stage does not hide a mode mix-up through its one-cycle delay.

// File: rtl/eag_pkg.sv
package eag_pkg;

    localparam int EAG_ADDR_W  = 32;
    localparam int EAG_FIELD_W = 16;
    localparam int EAG_MODE_W  = 3;

    typedef enum logic [EAG_MODE_W-1:0] {
        EAG_ABS   = 3'd0,
        EAG_IND   = 3'd1,
        EAG_DISP  = 3'd2,
        EAG_BIDX  = 3'd3,
        EAG_POSTI = 3'd4,
        EAG_PRED  = 3'd5,
        EAG_RSV6  = 3'd6,
        EAG_RSV7  = 3'd7
    } eag_mode_e;

    typedef enum logic {
        EAG_SZ_BYTE = 1'b0,
        EAG_SZ_WORD = 1'b1
    } eag_size_e;

endpackage

// File: rtl/eag_sext.sv
module eag_sext #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 32
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    localparam int PAD_W = OUT_W - IN_W;

    generate
        if (PAD_W > 0) begin : g_pad
            assign val_o = {{PAD_W{val_i[IN_W-1]}}, val_i};
        end else begin : g_trunc
            assign val_o = val_i[OUT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/eag_step.sv
module eag_step #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              size_i,
    input  logic [ADDR_W-1:0] ptr_i,
    output logic [ADDR_W-1:0] inc_o,
    output logic [ADDR_W-1:0] dec_o
);
    localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(WORD_BYTES);
    localparam logic [ADDR_W-1:0] STEP_BYTE = ADDR_W'(1);

    logic [ADDR_W-1:0] step;

    always_comb begin
        step  = size_i ? STEP_WORD : STEP_BYTE;
        inc_o = ptr_i + step;
        dec_o = ptr_i - step;
    end
endmodule

// File: rtl/eag_sum3.sv
module eag_sum3 #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] a_i,
    input  logic [ADDR_W-1:0] b_i,
    input  logic [ADDR_W-1:0] disp_i,
    output logic [ADDR_W-1:0] ab_disp_o,
    output logic [ADDR_W-1:0] a_disp_o
);
    always_comb begin
        a_disp_o  = a_i + disp_i;
        ab_disp_o = a_disp_o + b_i;
    end
endmodule

// File: rtl/eag_unit.sv
module eag_unit #(
    parameter int ADDR_W     = eag_pkg::EAG_ADDR_W,
    parameter int FIELD_W    = eag_pkg::EAG_FIELD_W,
    parameter int WORD_BYTES = 4,
    parameter bit REG_OUT    = 1'b1
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [eag_pkg::EAG_MODE_W-1:0]     mode_i,
    input  logic                               size_i,
    input  logic [ADDR_W-1:0]                  base_i,
    input  logic [ADDR_W-1:0]                  index_i,
    input  logic [FIELD_W-1:0]                 field_i,
    output logic [ADDR_W-1:0]                  ea_o,
    output logic [ADDR_W-1:0]                  ptr_o,
    output logic                               ptr_we_o
);
    import eag_pkg::*;

    typedef struct packed {
        logic [ADDR_W-1:0] ea;
        logic [ADDR_W-1:0] ptr;
        logic              we;
    } eag_res_t;

    logic [ADDR_W-1:0] disp_ext;
    logic [ADDR_W-1:0] ptr_inc;
    logic [ADDR_W-1:0] ptr_dec;
    logic [ADDR_W-1:0] sum_bid;
    logic [ADDR_W-1:0] sum_bd;
    eag_res_t          res_d;
    eag_res_t          res_q;

    eag_sext #(.IN_W(FIELD_W), .OUT_W(ADDR_W)) u_sext (
        .val_i (field_i),
        .val_o (disp_ext)
    );

    eag_step #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_step (
        .size_i (size_i),
        .ptr_i  (base_i),
        .inc_o  (ptr_inc),
        .dec_o  (ptr_dec)
    );

    eag_sum3 #(.ADDR_W(ADDR_W)) u_sum (
        .a_i       (base_i),
        .b_i       (index_i),
        .disp_i    (disp_ext),
        .ab_disp_o (sum_bid),
        .a_disp_o  (sum_bd)
    );

    always_comb begin
        res_d.ea  = '0;
        res_d.ptr = base_i;
        res_d.we  = 1'b0;
        unique case (eag_mode_e'(mode_i))
            EAG_ABS:   res_d.ea = disp_ext;
            EAG_IND:   res_d.ea = base_i;
            EAG_DISP:  res_d.ea = sum_bd;
            EAG_BIDX:  res_d.ea = sum_bid;
            EAG_POSTI: begin
                res_d.ea  = base_i;
                res_d.ptr = ptr_inc;
                res_d.we  = 1'b1;
            end
            EAG_PRED: begin
                res_d.ea  = ptr_dec;
                res_d.ptr = ptr_dec;
                res_d.we  = 1'b1;
            end
            default: begin
                res_d.ea  = '0;
                res_d.ptr = base_i;
                res_d.we  = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    generate
        if (REG_OUT) begin : g_reg
            assign ea_o     = res_q.ea;
            assign ptr_o    = res_q.ptr;
            assign ptr_we_o = res_q.we;
        end else begin : g_comb
            assign ea_o     = res_d.ea;
            assign ptr_o    = res_d.ptr;
            assign ptr_we_o = res_d.we;
        end
    endgenerate
endmodule

// File: rtl/eag_unit_chk.sv
module eag_unit_chk #(
    parameter int ADDR_W     = 32,
    parameter int FIELD_W    = 16,
    parameter int WORD_BYTES = 4,
    parameter bit REG_OUT    = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        mode_i,
    input logic              size_i,
    input logic [ADDR_W-1:0] base_i,
    input logic [ADDR_W-1:0] index_i,
    input logic [FIELD_W-1:0] field_i,
    input logic [ADDR_W-1:0] ea_o,
    input logic [ADDR_W-1:0] ptr_o,
    input logic              ptr_we_o
);
    localparam logic [ADDR_W-1:0] WSTEP = ADDR_W'(WORD_BYTES);

    generate
        if (REG_OUT) begin : g_seq
            // R2
            a_r2_indirect: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == 3'd1) |=> (ea_o == $past(base_i)));
            // R5, R7
            a_r5_postinc_word: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == 3'd4 && size_i) |=>
                (ea_o == $past(base_i) && ptr_o == $past(base_i) + WSTEP && ptr_we_o));
            // R6, R7
            a_r6_predec_byte: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == 3'd5 && !size_i) |=>
                (ea_o == $past(base_i) - 1 && ptr_o == ea_o && ptr_we_o));
            // R8
            a_r8_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i < 3'd4) |=> (!ptr_we_o && ptr_o == $past(base_i)));
            // R10
            a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i > 3'd5) |=> (ea_o == '0 && !ptr_we_o));
            // R11
            a_r11_reset_clear: assert property (@(posedge clk)
                $past(!rst_n) |-> (ea_o == '0 && ptr_o == '0 && !ptr_we_o));
        end else begin : g_cmb
            // R2
            a_r2_indirect: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == 3'd1) |-> (ea_o == base_i));
            // R5, R7
            a_r5_postinc_word: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == 3'd4 && size_i) |->
                (ea_o == base_i && ptr_o == base_i + WSTEP && ptr_we_o));
            // R6, R7
            a_r6_predec_byte: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i == 3'd5 && !size_i) |->
                (ea_o == base_i - 1 && ptr_o == ea_o && ptr_we_o));
            // R8
            a_r8_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i < 3'd4) |-> (!ptr_we_o && ptr_o == base_i));
            // R10
            a_r10_reserved: assert property (@(posedge clk) disable iff (!rst_n)
                (mode_i > 3'd5) |-> (ea_o == '0 && !ptr_we_o));
        end
    endgenerate

    logic unused_ok;
    assign unused_ok = ^{index_i, field_i};
endmodule

bind eag_unit eag_unit_chk #(
    .ADDR_W(ADDR_W), .FIELD_W(FIELD_W), .WORD_BYTES(WORD_BYTES), .REG_OUT(REG_OUT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .size_i(size_i),
    .base_i(base_i), .index_i(index_i), .field_i(field_i),
    .ea_o(ea_o), .ptr_o(ptr_o), .ptr_we_o(ptr_we_o)
);

// File: tb/eag_unit_test.sv
`timescale 1ns/1ps
module eag_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic        size = 1'b0;
    logic [31:0] base = '0;
    logic [31:0] index = '0;
    logic [15:0] field = '0;
    logic [31:0] ea_r, ptr_r, ea_c, ptr_c;
    logic        we_r, we_c;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    eag_unit #(.REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .size_i(size),
        .base_i(base), .index_i(index), .field_i(field),
        .ea_o(ea_r), .ptr_o(ptr_r), .ptr_we_o(we_r)
    );

    eag_unit #(.REG_OUT(1'b0)) uut_c (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .size_i(size),
        .base_i(base), .index_i(index), .field_i(field),
        .ea_o(ea_c), .ptr_o(ptr_c), .ptr_we_o(we_c)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    function automatic logic [31:0] sx(input logic [15:0] f);
        return {{16{f[15]}}, f};
    endfunction

    // Drives one operation, checks the combinational copy at once and the
    // registered copy after the next rising edge.
    task automatic run(input string req, input logic [2:0] m, input logic s,
                       input logic [31:0] b, input logic [31:0] x, input logic [15:0] f,
                       input logic [31:0] e_ea, input logic [31:0] e_ptr, input logic e_we);
        mode = m; size = s; base = b; index = x; field = f;
        #1;
        chk({req, " comb ea"}, ea_c, e_ea);
        chk({req, " comb ptr"}, ptr_c, e_ptr);
        chk({req, " comb we"}, {31'd0, we_c}, {31'd0, e_we});
        @(negedge clk);
        chk({req, " reg ea"}, ea_r, e_ea);
        chk({req, " reg ptr"}, ptr_r, e_ptr);
        chk({req, " reg we"}, {31'd0, we_r}, {31'd0, e_we});
    endtask

    task automatic t_reset;
        mode = 3'd4; size = 1'b1; base = 32'h1234_5678;
        @(negedge clk);
        chk("R11 reset ea", ea_r, 32'h0);
        chk("R11 reset ptr", ptr_r, 32'h0);
        chk("R11 reset we", {31'd0, we_r}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_absolute;
        run("R1 pos", 3'd0, 1'b1, 32'hDEAD_BEEF, 32'h1, 16'h1234, sx(16'h1234), 32'hDEAD_BEEF, 1'b0);
        run("R1 neg", 3'd0, 1'b0, 32'h0, 32'h0, 16'h8001, 32'hFFFF_8001, 32'h0, 1'b0);
    endtask

    task automatic t_indirect;
        run("R2", 3'd1, 1'b1, 32'h0000_1000, 32'h55, 16'h7777, 32'h0000_1000, 32'h0000_1000, 1'b0);
    endtask

    task automatic t_disp;
        run("R3 pos", 3'd2, 1'b0, 32'h0000_1000, 32'h9, 16'd20, 32'h0000_1014, 32'h0000_1000, 1'b0);
        run("R3 neg", 3'd2, 1'b1, 32'h0000_1000, 32'h9, 16'hFFF0, 32'h0000_0FF0, 32'h0000_1000, 1'b0);
    endtask

    task automatic t_bidx;
        run("R4", 3'd3, 1'b0, 32'h0000_1000, 32'h0000_0200, 16'd12,
            32'h0000_120C, 32'h0000_1000, 1'b0);
        run("R4 R9 wrap", 3'd3, 1'b1, 32'hFFFF_FFF0, 32'hFFFF_FFF0, 16'h0030,
            32'h0000_0010, 32'hFFFF_FFF0, 1'b0);
    endtask

    task automatic t_postinc;
        run("R5 R7 word", 3'd4, 1'b1, 32'h0000_2000, 32'h0, 16'h0, 32'h0000_2000, 32'h0000_2004, 1'b1);
        run("R5 R7 byte", 3'd4, 1'b0, 32'h0000_2000, 32'h0, 16'h0, 32'h0000_2000, 32'h0000_2001, 1'b1);
        run("R5 R9 wrap", 3'd4, 1'b1, 32'hFFFF_FFFE, 32'h0, 16'h0, 32'hFFFF_FFFE, 32'h0000_0002, 1'b1);
    endtask

    task automatic t_predec;
        run("R6 R7 word", 3'd5, 1'b1, 32'h0000_2000, 32'h0, 16'h0, 32'h0000_1FFC, 32'h0000_1FFC, 1'b1);
        run("R6 R7 byte", 3'd5, 1'b0, 32'h0000_2000, 32'h0, 16'h0, 32'h0000_1FFF, 32'h0000_1FFF, 1'b1);
        run("R6 R9 wrap", 3'd5, 1'b0, 32'h0000_0000, 32'h0, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1);
    endtask

    task automatic t_nowb;
        // R8: displacement with nonzero field still leaves the pointer untouched
        run("R8", 3'd2, 1'b1, 32'h0000_3000, 32'h4, 16'h0004, 32'h0000_3004, 32'h0000_3000, 1'b0);
    endtask

    task automatic t_reserved;
        run("R10 code6", 3'd6, 1'b1, 32'h0000_4000, 32'h8, 16'h0100, 32'h0, 32'h0000_4000, 1'b0);
        run("R10 code7", 3'd7, 1'b0, 32'h0000_5000, 32'h8, 16'h0100, 32'h0, 32'h0000_5000, 1'b0);
    endtask

    task automatic t_latency;
        run("R11 prime", 3'd1, 1'b0, 32'h0000_AAAA, 32'h0, 16'h0, 32'h0000_AAAA, 32'h0000_AAAA, 1'b0);
        mode = 3'd1; base = 32'h0000_BBBB;
        #1;
        chk("R11 held before edge", ea_r, 32'h0000_AAAA);
        chk("R11 comb follows", ea_c, 32'h0000_BBBB);
        @(negedge clk);
        chk("R11 after edge", ea_r, 32'h0000_BBBB);
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        @(negedge clk);
        t_reset();
        t_absolute();
        t_indirect();
        t_disp();
        t_bidx();
        t_postinc();
        t_predec();
        t_nowb();
        t_reserved();
        t_latency();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule